// File: doc/BRIEF.md
# Separate-Sync Video Input Sampler

This block takes video that arrives with its synchronization on dedicated wires (a picture-enable level, horizontal and vertical sync levels and a field flag) and turns it into a qualified pixel stream. It marks the start of each line and of each frame. It latches the field of each frame. It measures the active width and height of every complete frame and publishes them with a one-cycle done strobe.

A sample qualifier gates every input. Only cycles with the qualifier high carry a sample. This lets the same logic serve a video clock that runs at the pixel rate, with the qualifier tied high, and a video clock that oversamples the pixel stream, with the qualifier pulsing once per pixel.

After reset the block stays silent until it sees the first vertical sync rising edge. Because of this it never reports a partial frame. The horizontal sync level is accepted but has no effect. Line boundaries are taken from the picture enable instead.

Top module: `vss_sampler`

## Requirements
- R1: On a cycle with `in_valid_i` low, all other video inputs are ignored. No output pulse is produced, and the remembered levels of enable and vertical sync (used for edge detection) are unchanged.
- R2: Every qualified sample with `pic_en_i` high (active high) after lock appears one clock later as `pix_valid_o` high, with `pix_data_o` equal to that sample's data. Samples with `pic_en_i` low never raise `pix_valid_o`.
- R3: `sol_o` is high together with `pix_valid_o` for the first qualified active sample whose previous qualified sample had `pic_en_i` low. It is low for every other pixel.
- R4: `sof_o` is high together with `pix_valid_o` for the first active sample after a qualified rising edge of `vsync_i` (active high). `field_o` takes the value of `field_i` on that sample (1 = field 1 of interlaced video, 0 = progressive or field 0) and changes at no other time.
- R5: At each qualified `vsync_i` rising edge that closes a frame, `frame_done_o` pulses high for exactly one clock, one clock after the sample. `act_width_o` then equals the number of active samples on the frame's last line and `act_height_o` the number of lines, and both hold until the next pulse.
- R6: After `rst_ni` (asynchronous, active low) all outputs are zero. No pixel or marker is produced until a qualified `vsync_i` rising edge. A `vsync_i` level already high out of reset does not count as an edge, and the locking edge does not pulse `frame_done_o`.
- R7: With the qualifier pulsing once every N clocks, the markers, pixel data and measured sizes match those of the same video sent with the qualifier tied high.
- R8: Width and height counts saturate at `MAX_WIDTH` and `MAX_HEIGHT` and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Video clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample qualifier |
| in_data_i | input | DATA_W | Pixel data |
| pic_en_i | input | 1 | Active-picture enable, high outside blanking |
| hsync_i | input | 1 | Horizontal sync level, active high |
| vsync_i | input | 1 | Vertical sync level, active high |
| field_i | input | 1 | Field flag, 1 = field 1 |
| pix_valid_o | output | 1 | Pixel strobe |
| pix_data_o | output | DATA_W | Pixel data |
| sol_o | output | 1 | Start-of-line marker |
| sof_o | output | 1 | Start-of-frame marker |
| field_o | output | 1 | Field of the current frame |
| frame_done_o | output | 1 | Frame measured strobe |
| act_width_o | output | $clog2(MAX_WIDTH+1) | Active width of last frame |
| act_height_o | output | $clog2(MAX_HEIGHT+1) | Active height of last frame |

## Verification
The bench fills every gap between qualified samples with junk: the enable and vertical sync held high and the field flag inverted. A design that looked at unqualified cycles would then emit spurious pixels, lose the start-of-line marker or see a false frame edge. The first frame after reset is checked to produce no done pulse and no measurement, so a block that reported a partial frame fails at once. The field flag is changed during the vertical interval to catch a field output that follows the input instead of latching at frame start. An oversize frame checks that the counts saturate at their limits instead of wrapping to small values.

// File: rtl/vss_pkg.sv
package vss_pkg;
  typedef struct packed {
    logic en;
    logic vs;
  } lvl_state_t;
endpackage

// File: rtl/vss_qualify.sv
module vss_qualify
  import vss_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic en_i,
  input  logic vs_i,
  output logic vs_rise_o,
  output logic en_rise_o,
  output logic active_o
);
  lvl_state_t prev_q;
  logic       locked_q;

  assign vs_rise_o = valid_i & vs_i & ~prev_q.vs;
  assign en_rise_o = valid_i & en_i & ~prev_q.en;
  assign active_o  = valid_i & en_i & (locked_q | vs_rise_o);

  // vs resets high so a level already asserted is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '{en: 1'b0, vs: 1'b1};
      locked_q <= 1'b0;
    end else if (valid_i) begin
      prev_q <= '{en: en_i, vs: vs_i};
      if (vs_rise_o) locked_q <= 1'b1;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(prev_q)); // R1
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q); // R6
endmodule

// File: rtl/vss_mark.sv
module vss_mark #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              active_i,
  input  logic              en_rise_i,
  input  logic              vs_rise_i,
  input  logic              fld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sof_evt_o,
  output logic              sol_evt_o,
  output logic              pix_valid_o,
  output logic [DATA_W-1:0] pix_data_o,
  output logic              sol_o,
  output logic              sof_o,
  output logic              field_o
);
  logic armed_q;

  assign sof_evt_o = active_i & (armed_q | vs_rise_i);
  assign sol_evt_o = active_i & en_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q     <= 1'b0;
      pix_valid_o <= 1'b0;
      pix_data_o  <= '0;
      sol_o       <= 1'b0;
      sof_o       <= 1'b0;
      field_o     <= 1'b0;
    end else begin
      pix_valid_o <= active_i;
      sol_o       <= sol_evt_o;
      sof_o       <= sof_evt_o;
      if (active_i)  pix_data_o <= data_i;
      if (sof_evt_o) field_o    <= fld_i;
      if (sof_evt_o)      armed_q <= 1'b0;
      else if (vs_rise_i) armed_q <= 1'b1;
    end
  end

  AST_PIX_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(valid_i)); // R1
  AST_SOL_ON_PIXEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_o |-> pix_valid_o); // R3
  AST_SOF_ON_PIXEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> pix_valid_o); // R4
  AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field_o) |-> sof_o); // R4
endmodule

// File: rtl/vss_measure.sv
module vss_measure #(
  parameter int MAX_W = 4095,
  parameter int MAX_H = 4095,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          sol_i,
  input  logic          sof_i,
  input  logic          vs_rise_i,
  output logic [WW-1:0] width_o,
  output logic [HW-1:0] height_o,
  output logic          done_o
);
  localparam logic [WW-1:0] W_LIM = WW'(MAX_W);
  localparam logic [HW-1:0] H_LIM = HW'(MAX_H);

  logic [WW-1:0] cnt_w, w_next;
  logic [HW-1:0] cnt_h, h_next;
  logic          open_q;
  logic          line_start;

  assign w_next     = (cnt_w == W_LIM) ? cnt_w : cnt_w + 1'b1;
  assign h_next     = (cnt_h == H_LIM) ? cnt_h : cnt_h + 1'b1;
  assign line_start = sol_i | sof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_w    <= '0;
      cnt_h    <= '0;
      open_q   <= 1'b0;
      width_o  <= '0;
      height_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (vs_rise_i && open_q) begin
        width_o  <= cnt_w;
        height_o <= cnt_h;
        done_o   <= 1'b1;
      end
      if (vs_rise_i) begin
        open_q <= 1'b0;
        cnt_w  <= '0;
        cnt_h  <= '0;
      end
      // later assignments win: a sample may close one frame and open the next
      if (active_i) begin
        if (line_start) begin
          cnt_w <= WW'(1);
          cnt_h <= sof_i ? HW'(1) : h_next;
        end else begin
          cnt_w <= w_next;
        end
        if (sof_i) open_q <= 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w <= W_LIM) && (cnt_h <= H_LIM)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(width_o) && $stable(height_o))); // R5
endmodule

// File: rtl/vss_sampler.sv
module vss_sampler #(
  parameter int DATA_W     = 8,
  parameter int MAX_WIDTH  = 4095,
  parameter int MAX_HEIGHT = 4095,
  localparam int WW = $clog2(MAX_WIDTH + 1),
  localparam int HW = $clog2(MAX_HEIGHT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              pic_en_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              field_i,
  output logic              pix_valid_o,
  output logic [DATA_W-1:0] pix_data_o,
  output logic              sol_o,
  output logic              sof_o,
  output logic              field_o,
  output logic              frame_done_o,
  output logic [WW-1:0]     act_width_o,
  output logic [HW-1:0]     act_height_o
);
  logic vs_rise, en_rise, active, sof_evt, sol_evt;
  // line boundaries come from the enable edge, not from hsync
  logic unused_hsync;
  assign unused_hsync = hsync_i;

  vss_qualify u_qualify (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (in_valid_i),
    .en_i      (pic_en_i),
    .vs_i      (vsync_i),
    .vs_rise_o (vs_rise),
    .en_rise_o (en_rise),
    .active_o  (active)
  );

  vss_mark #(.DATA_W(DATA_W)) u_mark (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (in_valid_i),
    .active_i    (active),
    .en_rise_i   (en_rise),
    .vs_rise_i   (vs_rise),
    .fld_i       (field_i),
    .data_i      (in_data_i),
    .sof_evt_o   (sof_evt),
    .sol_evt_o   (sol_evt),
    .pix_valid_o (pix_valid_o),
    .pix_data_o  (pix_data_o),
    .sol_o       (sol_o),
    .sof_o       (sof_o),
    .field_o     (field_o)
  );

  vss_measure #(.MAX_W(MAX_WIDTH), .MAX_H(MAX_HEIGHT)) u_measure (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .sol_i     (sol_evt),
    .sof_i     (sof_evt),
    .vs_rise_i (vs_rise),
    .width_o   (act_width_o),
    .height_o  (act_height_o),
    .done_o    (frame_done_o)
  );
endmodule

// File: tb/vss_sampler_test.sv
`timescale 1ns/1ps
module vss_sampler_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       pic_en = 1'b0, hsync = 1'b0, vsync = 1'b1, fld = 1'b0;
  logic       pix_valid_o, sol_o, sof_o, field_o, frame_done_o;
  logic [7:0] pix_data_o;
  logic [3:0] act_width_o;
  logic [2:0] act_height_o;

  int checks = 0, errors = 0, ovs = 0;
  bit last_field = 1'b0;

  always #2.5 clk = ~clk;

  vss_sampler #(.DATA_W(8), .MAX_WIDTH(15), .MAX_HEIGHT(7)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_data_i(in_data),
    .pic_en_i(pic_en), .hsync_i(hsync), .vsync_i(vsync), .field_i(fld),
    .pix_valid_o(pix_valid_o), .pix_data_o(pix_data_o), .sol_o(sol_o),
    .sof_o(sof_o), .field_o(field_o), .frame_done_o(frame_done_o),
    .act_width_o(act_width_o), .act_height_o(act_height_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // junk-filled unqualified cycles, then one qualified sample; outputs read 1 ns after the edge
  task automatic smp(input bit en, input bit hs, input bit vs, input bit f, input logic [7:0] d);
    for (int k = 0; k < ovs; k++) begin
      @(negedge clk);
      in_valid = 1'b0; pic_en = 1'b1; hsync = 1'b1; vsync = 1'b1; fld = ~f; in_data = 8'hEE;
      @(posedge clk); #1;
      chk(!pix_valid_o && !frame_done_o && !sol_o, "R1 idle cycle pulse", int'(pix_valid_o), 0);
    end
    @(negedge clk);
    in_valid = 1'b1; pic_en = en; hsync = hs; vsync = vs; fld = f; in_data = d;
    @(posedge clk); #1;
  endtask

  task automatic vs_open(input bit exp_done, input int ew, input int eh, input bit f, input string req);
    smp(0, 0, 1, f, 8'h00);
    chk(frame_done_o == exp_done, req, int'(frame_done_o), int'(exp_done));
    if (exp_done) begin
      chk(act_width_o == ew, {req, " width"}, int'(act_width_o), ew);
      chk(act_height_o == eh, {req, " height"}, int'(act_height_o), eh);
    end
    chk(field_o == last_field, "R4 field held in vblank", int'(field_o), int'(last_field));
    smp(0, 0, 1, f, 8'h00);
    chk(!frame_done_o, "R5 done single pulse", int'(frame_done_o), 0);
    smp(0, 0, 0, f, 8'h00);
  endtask

  task automatic body(input int w, input int h, input bit f);
    for (int l = 0; l < h; l++) begin
      smp(0, 1, 0, f, 8'h00);
      chk(!pix_valid_o, "R2 blank no pixel", int'(pix_valid_o), 0);
      for (int i = 0; i < w; i++) begin
        logic [7:0] d;
        d = 8'((l * 16 + i) ^ 8'h5A);
        smp(1, 0, 0, f, d);
        chk(pix_valid_o, "R2 pixel strobe", int'(pix_valid_o), 1);
        chk(pix_data_o == d, "R2 pixel data", int'(pix_data_o), int'(d));
        chk(sol_o == (i == 0), "R3 start of line", int'(sol_o), int'(i == 0));
        chk(sof_o == (l == 0 && i == 0), "R4 start of frame", int'(sof_o), int'(l == 0 && i == 0));
        chk(field_o == f, "R4 field latched", int'(field_o), int'(f));
      end
    end
    smp(0, 0, 0, f, 8'h00);
    last_field = f;
  endtask

  task automatic t_reset;
    #1;
    chk(!pix_valid_o && !sol_o && !sof_o && !frame_done_o, "R6 reset markers", int'(pix_valid_o), 0);
    chk(act_width_o == 0 && act_height_o == 0 && !field_o, "R6 reset sizes", int'(act_width_o), 0);
  endtask

  task automatic t_prelock;
    smp(1, 0, 1, 1, 8'h11);
    chk(!pix_valid_o, "R6 vsync high from reset is no edge", int'(pix_valid_o), 0);
    smp(1, 0, 0, 1, 8'h12);
    chk(!pix_valid_o && !sof_o, "R6 no pixel before lock", int'(pix_valid_o), 0);
    smp(0, 0, 0, 1, 8'h00);
  endtask

  task automatic t_frames;
    vs_open(1'b0, 0, 0, 1, "R6 no done on locking edge");
    body(5, 3, 1);
    vs_open(1'b1, 5, 3, 0, "R5 frame done");
    body(4, 2, 0);
    vs_open(1'b1, 4, 2, 1, "R5 second frame");
  endtask

  task automatic t_oversampled;
    ovs = 2;
    body(6, 2, 1);
    vs_open(1'b1, 6, 2, 0, "R7 oversampled done");
    ovs = 0;
  endtask

  task automatic t_saturate;
    body(17, 9, 0);
    vs_open(1'b1, 15, 7, 0, "R8 saturated");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_ni = 1'b1;
    t_prelock();
    t_frames();
    t_oversampled();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #900us;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule